// File: doc/BRIEF.md
# Variable-Page Translation Buffer

A sixteen-entry, fully associative address translation buffer in which every entry carries its own page size. A page of size selector `sz` spans 1024 × 4^sz bytes. An entry holds an effective page number, a real page number, a 12-bit translation ID, a space bit, ten permission bits and seven memory attribute bits. A lookup presents a 32-bit effective address, an address-space bit and three process IDs. It returns whether a translation was found, which entry supplied it, the physical address and the permission and attribute bits.

Entries are installed or disabled by index through a write request. Before an entry is enabled, the hardware checks the index, the alignment of both addresses and overlap with every other live entry, and it reports a status code. Software therefore cannot build a pair of entries that would translate the same address ambiguously. An invalidate request clears one entry, but it refuses to remove the entry that translates effective address 0 in space 0.

Control is a single state machine with six states. IDLE accepts one request. WRITE and INVAL each take one cycle and return to IDLE. A lookup walks LOOK0, LOOK1 and LOOK2, searching with one process ID per state. It returns to IDLE on the first hit, or after LOOK2 on a miss. `busy` is high whenever the machine is outside IDLE. A request raised while `busy` is high is not taken. If several requests are raised in the same IDLE cycle, a write is taken first, then an invalidate, then a lookup.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every entry is invalid, `busy` is low, no done strobe is raised, and any lookup misses.
- R2: An entry matches a lookup only when all four of these hold: it is valid; its space bit equals `lk_as`; its translation ID is zero or equals the process ID being tried; and the address lies in its page.
- R3: A lookup tries `lk_pid0`, then `lk_pid1`, then `lk_pid2`, one per cycle, and the first process ID that produces a match wins. `lk_done` rises 2, 3 or 4 cycles after the request edge for a hit on the first, second or third ID. A miss is reported after 4 cycles with hit, index, address, permission and attribute outputs all zero.
- R4: When several entries match under the winning process ID, the lowest-numbered one is reported.
- R5: The physical address takes the real page bits above the page-offset width and the effective address bits below it. The stored permission and attribute bits are returned unchanged.
- R6: An entry with selector `sz` covers effective addresses from EPN×4096 through EPN×4096 + 1024×4^sz − 1. The 1 KiB page (sz=0) is included.
- R7: A write or disable to an index above 15 is rejected with status 17 and changes nothing.
- R8: An enabling write whose effective or physical address is not aligned to the larger of the page size and 4 KiB is rejected with status 18 and changes nothing.
- R9: An enabling write is rejected if its range overlaps a valid entry at another index that has the same space bit and whose translation ID is zero or equal to the new one. The status is then the lowest such index plus 1. Rewriting the same index over its own range is allowed, and on success the status is 0.
- R10: A write with `wr_enable` low clears the indexed entry with status 0, skipping the alignment and overlap checks.
- R11: An invalidate clears the indexed entry (`inv_ok` = 1). It is refused (`inv_ok` = 0, entry kept) when the index is above 15, or when the target is valid, in space 0 and covers effective address 0.
- R12: Each write and invalidate completes 2 cycles after its request edge. `busy` is high from the cycle after a request is taken until its single done strobe, and exactly one result is produced per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request, taken when `busy` is low |
| lk_ea | input | 32 | Effective address to translate |
| lk_as | input | 1 | Address space of the lookup |
| lk_pid0 | input | 12 | Process ID tried first |
| lk_pid1 | input | 12 | Process ID tried second |
| lk_pid2 | input | 12 | Process ID tried third |
| wr_req | input | 1 | Write request |
| wr_idx | input | 5 | Target entry index (values above 15 are invalid) |
| wr_enable | input | 1 | 1 installs a valid entry, 0 disables it |
| wr_ea | input | 32 | Effective base address |
| wr_pa | input | 32 | Physical base address |
| wr_sz | input | 4 | Page size selector |
| wr_tid | input | 12 | Translation ID (0 matches every process) |
| wr_ts | input | 1 | Space bit of the entry |
| wr_perm | input | 10 | Permission bits |
| wr_attr | input | 7 | Memory attribute bits |
| inv_req | input | 1 | Invalidate request |
| inv_idx | input | 5 | Entry to invalidate |
| busy | output | 1 | Machine is outside IDLE |
| lk_done | output | 1 | One-cycle strobe: lookup result valid |
| lk_hit | output | 1 | Translation found |
| lk_idx | output | 4 | Matching entry |
| lk_pa | output | 32 | Translated physical address |
| lk_perm | output | 10 | Permission bits of the match |
| lk_attr | output | 7 | Attribute bits of the match |
| wr_done | output | 1 | One-cycle strobe: write status valid |
| wr_status | output | 5 | 0 ok, 1..16 conflicting entry + 1, 17 bad index, 18 misaligned |
| inv_done | output | 1 | One-cycle strobe: invalidate result valid |
| inv_ok | output | 1 | Entry was cleared |

## Verification
The assertions assume that a request is raised only while `busy` is low and that at most one of the three request lines is high in a given cycle. Under those assumptions each done strobe can be tied to exactly one accepted request, and the captured request fields stay fixed until the result appears. The stimulus meets this by starting each operation only after the previous result has been seen with `busy` low, raising a single request line for one cycle, and holding every other request line at zero.

// File: rtl/vtlb_pkg.sv
package vtlb_pkg;

    typedef struct packed {
        logic        vld;
        logic        ts;
        logic [3:0]  sz;
        logic [11:0] tid;
        logic [19:0] epn;
        logic [19:0] rpn;
        logic [9:0]  perm;
        logic [6:0]  attr;
    } vtlb_entry_t;

    // Byte-offset mask of a page of 1024 * 4^sz bytes, saturated at 32 bits.
    function automatic logic [31:0] page_mask(input logic [3:0] sz);
        logic [5:0] sh;
        sh = 6'd10 + {1'b0, sz, 1'b0};
        if (sh >= 6'd32)
            page_mask = '1;
        else
            page_mask = (32'd1 << sh) - 32'd1;
    endfunction

endpackage

// File: rtl/vtlb_match.sv
module vtlb_match
    import vtlb_pkg::*;
#(
    parameter int N_ENT = 16
) (
    input  vtlb_entry_t [N_ENT-1:0] ents,
    input  logic [31:0]             ea,
    input  logic                    as_bit,
    input  logic [11:0]             pid,
    output logic [N_ENT-1:0]        hit_vec
);
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        logic tid_ok;
        logic in_page;
        assign tid_ok  = (ents[g].tid == 12'h000) || (ents[g].tid == pid);
        assign in_page = ~|((ea ^ {ents[g].epn, 12'h000}) & ~page_mask(ents[g].sz));
        assign hit_vec[g] = ents[g].vld && (ents[g].ts == as_bit) && tid_ok && in_page;
    end
endmodule

// File: rtl/vtlb_overlap.sv
module vtlb_overlap
    import vtlb_pkg::*;
#(
    parameter int N_ENT = 16,
    parameter int IDX_W = 4
) (
    input  vtlb_entry_t [N_ENT-1:0] ents,
    input  logic [31:0]             new_ea,
    input  logic [11:0]             new_tid,
    input  logic                    new_ts,
    input  logic [3:0]              new_sz,
    input  logic [IDX_W-1:0]        self_idx,
    output logic [N_ENT-1:0]        clash_vec
);
    // Aligned power-of-four ranges overlap exactly when they agree above the wider mask.
    for (genvar g = 0; g < N_ENT; g++) begin : g_ovl
        logic tid_ok;
        logic shared;
        assign tid_ok = (ents[g].tid == 12'h000) || (ents[g].tid == new_tid);
        assign shared = ~|((new_ea ^ {ents[g].epn, 12'h000})
                           & ~(page_mask(new_sz) | page_mask(ents[g].sz)));
        assign clash_vec[g] = ents[g].vld && (ents[g].ts == new_ts) && tid_ok && shared
                              && (IDX_W'(g) != self_idx);
    end
endmodule

// File: rtl/vtlb_first.sv
module vtlb_first #(
    parameter int N_ENT = 16,
    parameter int IDX_W = 4
) (
    input  logic [N_ENT-1:0] vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
    import vtlb_pkg::*;
#(
    parameter int N_ENT  = 16,
    parameter int IDX_W  = $clog2(N_ENT),
    parameter int REQ_IW = IDX_W + 1,
    parameter int STAT_W = $clog2(N_ENT + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [31:0]       lk_ea,
    input  logic              lk_as,
    input  logic [11:0]       lk_pid0,
    input  logic [11:0]       lk_pid1,
    input  logic [11:0]       lk_pid2,
    input  logic              wr_req,
    input  logic [REQ_IW-1:0] wr_idx,
    input  logic              wr_enable,
    input  logic [31:0]       wr_ea,
    input  logic [31:0]       wr_pa,
    input  logic [3:0]        wr_sz,
    input  logic [11:0]       wr_tid,
    input  logic              wr_ts,
    input  logic [9:0]        wr_perm,
    input  logic [6:0]        wr_attr,
    input  logic              inv_req,
    input  logic [REQ_IW-1:0] inv_idx,
    output logic              busy,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [31:0]       lk_pa,
    output logic [9:0]        lk_perm,
    output logic [6:0]        lk_attr,
    output logic              wr_done,
    output logic [STAT_W-1:0] wr_status,
    output logic              inv_done,
    output logic              inv_ok
);
    localparam logic [STAT_W-1:0] STAT_OK       = '0;
    localparam logic [STAT_W-1:0] STAT_BAD_IDX  = STAT_W'(N_ENT + 1);
    localparam logic [STAT_W-1:0] STAT_MISALIGN = STAT_W'(N_ENT + 2);
    localparam logic [REQ_IW-1:0] IDX_LIMIT     = REQ_IW'(N_ENT);

    typedef enum logic [2:0] {ST_IDLE, ST_LOOK0, ST_LOOK1, ST_LOOK2, ST_WRITE, ST_INVAL} fsm_e;

    fsm_e state_q, state_d;

    vtlb_entry_t [N_ENT-1:0] ent_q;

    logic [31:0]       q_ea, q_pa;
    logic              q_space, q_en;
    logic [11:0]       q_pid0, q_pid1, q_pid2, q_tid;
    logic [3:0]        q_sz;
    logic [REQ_IW-1:0] q_idx;
    logic [9:0]        q_perm;
    logic [6:0]        q_attr;

    logic [11:0]      cur_pid;
    logic [N_ENT-1:0] lk_vec, clash_vec;
    logic             lk_found, clash_found;
    logic [IDX_W-1:0] lk_first, clash_first, wsel;

    always_comb begin
        unique case (state_q)
            ST_LOOK1: cur_pid = q_pid1;
            ST_LOOK2: cur_pid = q_pid2;
            default:  cur_pid = q_pid0;
        endcase
    end

    vtlb_match #(.N_ENT(N_ENT)) u_match (
        .ents(ent_q), .ea(q_ea), .as_bit(q_space), .pid(cur_pid), .hit_vec(lk_vec)
    );

    vtlb_first #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_first_hit (
        .vec(lk_vec), .found(lk_found), .idx(lk_first)
    );

    assign wsel = q_idx[IDX_W-1:0];

    vtlb_overlap #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_overlap (
        .ents(ent_q), .new_ea(q_ea), .new_tid(q_tid), .new_ts(q_space),
        .new_sz(q_sz), .self_idx(wsel), .clash_vec(clash_vec)
    );

    vtlb_first #(.N_ENT(N_ENT), .IDX_W(IDX_W)) u_first_clash (
        .vec(clash_vec), .found(clash_found), .idx(clash_first)
    );

    // Write and invalidate qualification.
    logic              idx_bad, misaligned, holds_zero;
    logic [31:0]       align_mask, hit_mask;
    logic [STAT_W-1:0] wr_code;
    vtlb_entry_t       tgt, hit_ent;

    assign idx_bad    = (q_idx >= IDX_LIMIT);
    assign align_mask = page_mask(q_sz) | 32'h0000_0FFF;
    assign misaligned = q_en && ((|(q_ea & align_mask)) || (|(q_pa & align_mask)));
    assign tgt        = ent_q[wsel];
    assign holds_zero = tgt.vld && !tgt.ts && ~|({tgt.epn, 12'h000} & ~page_mask(tgt.sz));
    assign hit_ent    = ent_q[lk_first];
    assign hit_mask   = page_mask(hit_ent.sz);

    always_comb begin
        if (idx_bad)
            wr_code = STAT_BAD_IDX;
        else if (misaligned)
            wr_code = STAT_MISALIGN;
        else if (q_en && clash_found)
            wr_code = STAT_W'(clash_first) + STAT_W'(1);
        else
            wr_code = STAT_OK;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (wr_req)       state_d = ST_WRITE;
                else if (inv_req) state_d = ST_INVAL;
                else if (lk_req)  state_d = ST_LOOK0;
            end
            ST_LOOK0: state_d = lk_found ? ST_IDLE : ST_LOOK1;
            ST_LOOK1: state_d = lk_found ? ST_IDLE : ST_LOOK2;
            ST_LOOK2: state_d = ST_IDLE;
            ST_WRITE: state_d = ST_IDLE;
            ST_INVAL: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);

    // Request capture, entry storage and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q     <= '0;
            q_ea      <= '0;
            q_pa      <= '0;
            q_space   <= 1'b0;
            q_en      <= 1'b0;
            q_pid0    <= '0;
            q_pid1    <= '0;
            q_pid2    <= '0;
            q_tid     <= '0;
            q_sz      <= '0;
            q_idx     <= '0;
            q_perm    <= '0;
            q_attr    <= '0;
            lk_done   <= 1'b0;
            lk_hit    <= 1'b0;
            lk_idx    <= '0;
            lk_pa     <= '0;
            lk_perm   <= '0;
            lk_attr   <= '0;
            wr_done   <= 1'b0;
            wr_status <= '0;
            inv_done  <= 1'b0;
            inv_ok    <= 1'b0;
        end else begin
            lk_done  <= 1'b0;
            wr_done  <= 1'b0;
            inv_done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    q_ea    <= wr_req ? wr_ea : lk_ea;
                    q_space <= wr_req ? wr_ts : lk_as;
                    q_idx   <= wr_req ? wr_idx : inv_idx;
                    q_pa    <= wr_pa;
                    q_en    <= wr_enable;
                    q_sz    <= wr_sz;
                    q_tid   <= wr_tid;
                    q_perm  <= wr_perm;
                    q_attr  <= wr_attr;
                    q_pid0  <= lk_pid0;
                    q_pid1  <= lk_pid1;
                    q_pid2  <= lk_pid2;
                end
                ST_LOOK0, ST_LOOK1, ST_LOOK2: begin
                    if (lk_found) begin
                        lk_done <= 1'b1;
                        lk_hit  <= 1'b1;
                        lk_idx  <= lk_first;
                        lk_pa   <= ({hit_ent.rpn, 12'h000} & ~hit_mask) | (q_ea & hit_mask);
                        lk_perm <= hit_ent.perm;
                        lk_attr <= hit_ent.attr;
                    end else if (state_q == ST_LOOK2) begin
                        lk_done <= 1'b1;
                        lk_hit  <= 1'b0;
                        lk_idx  <= '0;
                        lk_pa   <= '0;
                        lk_perm <= '0;
                        lk_attr <= '0;
                    end
                end
                ST_WRITE: begin
                    wr_done   <= 1'b1;
                    wr_status <= wr_code;
                    if (wr_code == STAT_OK) begin
                        if (q_en)
                            ent_q[wsel] <= '{vld: 1'b1, ts: q_space, sz: q_sz, tid: q_tid,
                                             epn: q_ea[31:12], rpn: q_pa[31:12],
                                             perm: q_perm, attr: q_attr};
                        else
                            ent_q[wsel].vld <= 1'b0;
                    end
                end
                ST_INVAL: begin
                    inv_done <= 1'b1;
                    inv_ok   <= !idx_bad && !holds_zero;
                    if (!idx_bad && !holds_zero)
                        ent_q[wsel].vld <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Assertions.
    AST_BUSY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (lk_req || wr_req || inv_req)) |=> busy);  // R12
    AST_DONE_AT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done || wr_done || inv_done) |-> !busy);  // R12
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lk_done, wr_done, inv_done}));  // R12
    AST_LK_FROM_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> ($past(state_q) == ST_LOOK0 || $past(state_q) == ST_LOOK1
                     || $past(state_q) == ST_LOOK2));  // R3
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && !lk_hit) |-> (lk_pa == '0 && lk_perm == '0 && lk_attr == '0));  // R3
    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_done && lk_hit) |-> (lk_pa[9:0] == q_ea[9:0]));  // R5
    AST_DISABLE_OK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_done && !q_en && !idx_bad) |-> (wr_status == STAT_OK));  // R10
    AST_STATUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |-> (wr_status <= STAT_MISALIGN));  // R9
    AST_INV_BAD_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_done && q_idx >= IDX_LIMIT) |-> !inv_ok);  // R11

endmodule

// File: tb/vpage_tlb_tb.sv
`timescale 1ns/1ps
module vpage_tlb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0, lk_as = 1'b0;
    logic [31:0] lk_ea = '0;
    logic [11:0] lk_pid0 = '0, lk_pid1 = '0, lk_pid2 = '0;
    logic        wr_req = 1'b0, wr_enable = 1'b0, wr_ts = 1'b0;
    logic [4:0]  wr_idx = '0, inv_idx = '0;
    logic [31:0] wr_ea = '0, wr_pa = '0;
    logic [3:0]  wr_sz = '0;
    logic [11:0] wr_tid = '0;
    logic [9:0]  wr_perm = '0;
    logic [6:0]  wr_attr = '0;
    logic        inv_req = 1'b0;
    logic        busy, lk_done, lk_hit, wr_done, inv_done, inv_ok;
    logic [3:0]  lk_idx;
    logic [31:0] lk_pa;
    logic [9:0]  lk_perm;
    logic [6:0]  lk_attr;
    logic [4:0]  wr_status;

    vpage_tlb dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_req(lk_req), .lk_ea(lk_ea), .lk_as(lk_as),
        .lk_pid0(lk_pid0), .lk_pid1(lk_pid1), .lk_pid2(lk_pid2),
        .wr_req(wr_req), .wr_idx(wr_idx), .wr_enable(wr_enable), .wr_ea(wr_ea),
        .wr_pa(wr_pa), .wr_sz(wr_sz), .wr_tid(wr_tid), .wr_ts(wr_ts),
        .wr_perm(wr_perm), .wr_attr(wr_attr),
        .inv_req(inv_req), .inv_idx(inv_idx),
        .busy(busy), .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_pa(lk_pa), .lk_perm(lk_perm), .lk_attr(lk_attr),
        .wr_done(wr_done), .wr_status(wr_status),
        .inv_done(inv_done), .inv_ok(inv_ok)
    );

    always #4 clk = ~clk;  // 125 MHz

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit summary_done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          kind;   // 0 lookup, 1 write, 2 invalidate
        logic [63:0] exp;
        int          lat;
        int          issue;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        end
    endtask

    function automatic logic [63:0] lk_word(input bit hit, input logic [3:0] idx,
                                            input logic [31:0] pa, input logic [9:0] perm,
                                            input logic [6:0] attr);
        return {10'd0, hit, idx, pa, perm, attr};
    endfunction

    // Monitor: pops the scoreboard whenever a result strobe appears.
    always @(negedge clk) begin
        if (rst_n && (lk_done || wr_done || inv_done)) begin
            if (sb_q.size() == 0) begin
                chk(1'b0, "R12 result with no pending request", 64'd1, 64'd0);
            end else begin
                sb_item_t it;
                logic [63:0] act;
                logic kind_ok;
                it = sb_q.pop_front();
                case (it.kind)
                    0:       begin act = lk_word(lk_hit, lk_idx, lk_pa, lk_perm, lk_attr); kind_ok = lk_done; end
                    1:       begin act = {59'd0, wr_status}; kind_ok = wr_done; end
                    default: begin act = {63'd0, inv_ok}; kind_ok = inv_done; end
                endcase
                chk(kind_ok, {it.tag, " strobe kind"}, {61'd0, lk_done, wr_done, inv_done}, 64'(it.kind));
                chk(act == it.exp, it.tag, act, it.exp);
                chk((cyc - it.issue) == it.lat, {it.tag, " latency"}, 64'(cyc - it.issue), 64'(it.lat));
            end
        end
    end

    task automatic finish_op();
        @(negedge clk);
        lk_req = 1'b0; wr_req = 1'b0; inv_req = 1'b0;
        chk(busy == 1'b1, "R12 busy after accept", 64'(busy), 64'd1);
        while (busy) @(negedge clk);
    endtask

    task automatic do_lookup(input logic [31:0] ea, input bit as_b, input logic [11:0] p0,
                             input logic [11:0] p1, input logic [11:0] p2, input bit hit,
                             input logic [3:0] idx, input logic [31:0] pa,
                             input logic [9:0] perm, input logic [6:0] attr,
                             input int lat, input string tag);
        sb_item_t it;
        lk_ea = ea; lk_as = as_b; lk_pid0 = p0; lk_pid1 = p1; lk_pid2 = p2; lk_req = 1'b1;
        it.kind = 0; it.exp = lk_word(hit, idx, pa, perm, attr);
        it.lat = lat; it.issue = cyc; it.tag = tag;
        sb_q.push_back(it);
        finish_op();
    endtask

    task automatic do_write(input logic [4:0] idx, input bit en, input logic [31:0] ea,
                            input logic [31:0] pa, input logic [3:0] sz,
                            input logic [11:0] tid, input bit ts, input logic [9:0] perm,
                            input logic [6:0] attr, input logic [4:0] status,
                            input string tag);
        sb_item_t it;
        wr_idx = idx; wr_enable = en; wr_ea = ea; wr_pa = pa; wr_sz = sz;
        wr_tid = tid; wr_ts = ts; wr_perm = perm; wr_attr = attr; wr_req = 1'b1;
        it.kind = 1; it.exp = {59'd0, status}; it.lat = 2; it.issue = cyc; it.tag = tag;
        sb_q.push_back(it);
        finish_op();
    endtask

    task automatic do_inval(input logic [4:0] idx, input bit ok, input string tag);
        sb_item_t it;
        inv_idx = idx; inv_req = 1'b1;
        it.kind = 2; it.exp = {63'd0, ok}; it.lat = 2; it.issue = cyc; it.tag = tag;
        sb_q.push_back(it);
        finish_op();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog expired: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy after reset", 64'(busy), 64'd0);
        chk({lk_done, wr_done, inv_done} == 3'b000, "R1 no strobe after reset",
            64'({lk_done, wr_done, inv_done}), 64'd0);
        do_lookup(32'h0, 1'b0, 12'h0, 12'h0, 12'h0, 1'b0, 4'd0, 32'h0, 10'h0, 7'h0, 4, "R1 empty miss");

        // 16 KiB page at 0, global TID.
        do_write(5'd0, 1'b1, 32'h0000_0000, 32'h0010_0000, 4'd2, 12'h000, 1'b0, 10'h155, 7'h0A, 5'd0, "R6 install 16K");
        do_lookup(32'h0000_1234, 1'b0, 12'h005, 12'h0, 12'h0, 1'b1, 4'd0, 32'h0010_1234, 10'h155, 7'h0A, 2, "R5 translate");
        do_lookup(32'h0000_3FFF, 1'b0, 12'h005, 12'h0, 12'h0, 1'b1, 4'd0, 32'h0010_3FFF, 10'h155, 7'h0A, 2, "R6 last byte");
        do_lookup(32'h0000_4000, 1'b0, 12'h005, 12'h0, 12'h0, 1'b0, 4'd0, 32'h0, 10'h0, 7'h0, 4, "R6 past end");

        // 4 KiB page private to TID 7.
        do_write(5'd3, 1'b1, 32'h0002_0000, 32'h0800_0000, 4'd1, 12'h007, 1'b0, 10'h0F0, 7'h11, 5'd0, "R9 install tid7");
        do_lookup(32'h0002_0ABC, 1'b0, 12'h001, 12'h002, 12'h007, 1'b1, 4'd3, 32'h0800_0ABC, 10'h0F0, 7'h11, 4, "R3 hit on third pid");
        do_lookup(32'h0002_0ABC, 1'b0, 12'h001, 12'h007, 12'h009, 1'b1, 4'd3, 32'h0800_0ABC, 10'h0F0, 7'h11, 3, "R3 hit on second pid");
        do_lookup(32'h0002_0ABC, 1'b0, 12'h007, 12'h001, 12'h002, 1'b1, 4'd3, 32'h0800_0ABC, 10'h0F0, 7'h11, 2, "R3 hit on first pid");
        do_lookup(32'h0002_0ABC, 1'b1, 12'h007, 12'h007, 12'h007, 1'b0, 4'd0, 32'h0, 10'h0, 7'h0, 4, "R2 other space misses");

        // Overlap rules.
        do_write(5'd5, 1'b1, 32'h0002_0000, 32'h0900_0000, 4'd1, 12'h009, 1'b0, 10'h0, 7'h0, 5'd0, "R9 distinct tid allowed");
        do_write(5'd6, 1'b1, 32'h0002_0000, 32'h0A00_0000, 4'd1, 12'h007, 1'b1, 10'h111, 7'h22, 5'd0, "R9 other space allowed");
        do_lookup(32'h0002_0FFF, 1'b1, 12'h003, 12'h007, 12'h000, 1'b1, 4'd6, 32'h0A00_0FFF, 10'h111, 7'h22, 3, "R2 space-1 entry");
        do_write(5'd7, 1'b1, 32'h0000_2000, 32'h0B00_0000, 4'd1, 12'h003, 1'b0, 10'h0, 7'h0, 5'd1, "R9 clash with global entry 0");
        do_write(5'd8, 1'b1, 32'h0002_0000, 32'h0B00_0000, 4'd1, 12'h007, 1'b0, 10'h0, 7'h0, 5'd4, "R9 clash with entry 3");
        do_write(5'd3, 1'b1, 32'h0002_0000, 32'h0800_0000, 4'd1, 12'h007, 1'b0, 10'h0AA, 7'h11, 5'd0, "R9 rewrite own index");
        do_lookup(32'h0002_0000, 1'b0, 12'h007, 12'h0, 12'h0, 1'b1, 4'd3, 32'h0800_0000, 10'h0AA, 7'h11, 2, "R9 rewrite took effect");

        // Two entries match: lowest index wins.
        do_write(5'd1, 1'b1, 32'h0002_0000, 32'h0C00_0000, 4'd1, 12'h000, 1'b0, 10'h001, 7'h7F, 5'd0, "R9 global over private allowed");
        do_lookup(32'h0002_0010, 1'b0, 12'h007, 12'h0, 12'h0, 1'b1, 4'd1, 32'h0C00_0010, 10'h001, 7'h7F, 2, "R4 lowest index");

        // Index and alignment rejects.
        do_write(5'd16, 1'b1, 32'h0030_0000, 32'h0030_0000, 4'd1, 12'h0, 1'b0, 10'h0, 7'h0, 5'd17, "R7 index 16");
        do_write(5'd20, 1'b0, 32'h0, 32'h0, 4'd0, 12'h0, 1'b0, 10'h0, 7'h0, 5'd17, "R7 disable index 20");
        do_write(5'd9, 1'b1, 32'h0004_0800, 32'h0, 4'd1, 12'h0, 1'b0, 10'h0, 7'h0, 5'd18, "R8 ea misaligned");
        do_write(5'd9, 1'b1, 32'h0010_0000, 32'h0000_4000, 4'd3, 12'h0, 1'b0, 10'h0, 7'h0, 5'd18, "R8 pa misaligned");
        do_write(5'd9, 1'b1, 32'h0005_0400, 32'h0006_0000, 4'd0, 12'h0, 1'b0, 10'h0, 7'h0, 5'd18, "R8 4K floor");
        do_lookup(32'h0010_0000, 1'b0, 12'h0, 12'h0, 12'h0, 1'b0, 4'd0, 32'h0, 10'h0, 7'h0, 4, "R8 rejected write left no entry");

        // 1 KiB page.
        do_write(5'd9, 1'b1, 32'h0005_0000, 32'h0006_0000, 4'd0, 12'h0, 1'b0, 10'h200, 7'h01, 5'd0, "R6 install 1K");
        do_lookup(32'h0005_03FF, 1'b0, 12'h0, 12'h0, 12'h0, 1'b1, 4'd9, 32'h0006_03FF, 10'h200, 7'h01, 2, "R6 1K last byte");
        do_lookup(32'h0005_0400, 1'b0, 12'h0, 12'h0, 12'h0, 1'b0, 4'd0, 32'h0, 10'h0, 7'h0, 4, "R6 1K past end");

        // Disable skips checks.
        do_write(5'd1, 1'b0, 32'h0000_0123, 32'h0000_0456, 4'd5, 12'h0, 1'b0, 10'h0, 7'h0, 5'd0, "R10 disable");
        do_lookup(32'h0002_0010, 1'b0, 12'h007, 12'h0, 12'h0, 1'b1, 4'd3, 32'h0800_0010, 10'h0AA, 7'h11, 2, "R10 disabled entry skipped");

        // Invalidate.
        do_inval(5'd0, 1'b0, "R11 refuse address-0 entry");
        do_lookup(32'h0000_1234, 1'b0, 12'h005, 12'h0, 12'h0, 1'b1, 4'd0, 32'h0010_1234, 10'h155, 7'h0A, 2, "R11 entry 0 kept");
        do_inval(5'd17, 1'b0, "R11 refuse index 17");
        do_inval(5'd3, 1'b1, "R11 clear entry 3");
        do_lookup(32'h0002_0010, 1'b0, 12'h007, 12'h007, 12'h007, 1'b0, 4'd0, 32'h0, 10'h0, 7'h0, 4, "R11 cleared entry misses");
        do_write(5'd8, 1'b1, 32'h0002_0000, 32'h0900_0000, 4'd1, 12'h007, 1'b0, 10'h3FF, 7'h00, 5'd0, "R11 range free after clear");
        do_lookup(32'h0002_0010, 1'b0, 12'h001, 12'h002, 12'h007, 1'b1, 4'd8, 32'h0900_0010, 10'h3FF, 7'h00, 4, "R3 third pid new entry");
        do_write(5'd10, 1'b1, 32'h0000_0000, 32'h0F00_0000, 4'd1, 12'h0, 1'b1, 10'h0, 7'h0, 5'd0, "R9 space-1 at zero");
        do_inval(5'd10, 1'b1, "R11 space-1 zero entry clearable");

        @(negedge clk);
        chk(sb_q.size() == 0, "R12 every request answered", 64'(sb_q.size()), 64'd0);
        summary();
        $finish;
    end

endmodule